// File: doc/BRIEF.md
# VBI Framing-Code Hunter and Byte Packer

This block sits behind a data slicer that has already recovered bit timing on a vertical-blanking line. It receives one sliced bit per strobe, hunts inside a register-defined stretch of the line for the framing pattern of the selected data service, and then packs every following bit into bytes, least significant bit first. Each byte leaves on a one-cycle strobe together with a first-byte-of-line marker and, for services that carry Hamming 8/4 protected bytes, a check-failure flag. A line on which the pattern never shows up before the end of the window produces a single "no frame" pulse instead of data.

The service for a line is chosen from a small table indexed by the incoming line number minus a vertical offset. All configuration (table entry, offsets, error tolerance, programmable pattern) is captured when the line starts, so registers may change freely while a line is in progress. A three-state machine drives the flow: `ST_IDLE` (no line or disabled service), `ST_HUNT` (pattern search), `ST_COLLECT` (byte packing). Transitions: `ST_IDLE`→`ST_HUNT` on a line start with an enabled service; `ST_HUNT`→`ST_COLLECT` on a pattern hit before the last window bit; `ST_HUNT`/`ST_COLLECT`→`ST_IDLE` on the last window bit; any state→`ST_HUNT` or `ST_IDLE` on a new line start, depending on whether the new line is enabled.

Top module: `vbi_frame_assembler`

## Requirements
- R1: While `rst_n` is low, `byte_valid`, `byte_sop`, `byte_ham_err` and `no_frame` are 0, and no line is active after reset until a `line_start`.
- R2: At `line_start` the table index is `(line_num - v_off) mod 512`; the line is enabled only if the index is below NUM_LINES (8) and the 4-bit service code at `line_std[4*index +: 4]` is 0 to 8; codes 9 to 15 or an index out of range give no bytes and no `no_frame` for that line.
- R3: Service codes and patterns: 0 = 625-line teletext, 8'h27; 1 = closed caption, 3'b001; 2 = programme-delivery line, 16'h9951; 3 = widescreen signalling, 24'h1E3C1F; 4 = 525-line teletext, 8'h27; 5 = generic text, 6 = time code and 7 = NABTS use `prog_code`/`prog_len` (length clamped to 1..24); 8 = Japanese text, 8'hA7.
- R4: The pattern of length L is compared against the last L window bits with the earliest bit against pattern bit L-1; no hit is possible before L window bits have been received on the line.
- R5: A hit is declared when the number of differing bits among the L compared positions is at most `err_limit`.
- R6: Counting valid bits from 0 after `line_start`, only bits at positions `h_off` to `h_off + WIN_BITS - 1` (WIN_BITS = 256) take part in hunting or packing; earlier bits are ignored.
- R7: If the last window bit is consumed without a hit, `no_frame` is 1 for exactly one cycle, in the cycle after that bit, and no byte is produced for the line.
- R8: After a hit the following bits form bytes, the first bit in `byte_data[0]`; `byte_valid` pulses one cycle after the eighth bit; packing continues to the end of the window and an incomplete byte is dropped.
- R9: `byte_sop` is 1 together with the first `byte_valid` of a line and 0 for every later byte of that line.
- R10: `byte_ham_err` is 1 when any of these XORs is 0: bits {0,1,3,7}, bits {1,2,3,5}, bits {3,4,5,7}, all eight bits; it is checked for codes 0 and 4 always, for codes 5 and 7 only when `ham_opt_en` was 1 at line start, and is 0 for every other service.
- R11: A `line_start` abandons the current line at once; a bit strobed in the same cycle as `line_start` is ignored and the next byte strobe is at least nine cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Start of a new line, one-cycle pulse |
| line_num | input | 9 | Line number, sampled at `line_start` |
| bit_valid | input | 1 | Sliced bit strobe |
| bit_in | input | 1 | Sliced bit |
| line_std | input | 32 | Per-line service table, 4 bits per entry |
| v_off | input | 9 | Vertical offset subtracted from `line_num` |
| h_off | input | 11 | First window bit position |
| err_limit | input | 5 | Accepted pattern bit errors |
| prog_code | input | 24 | Programmable pattern |
| prog_len | input | 5 | Programmable pattern length |
| ham_opt_en | input | 1 | Enables Hamming check for optional services |
| byte_valid | output | 1 | Byte strobe |
| byte_data | output | 8 | Packed byte |
| byte_sop | output | 1 | First byte of the line |
| byte_ham_err | output | 1 | Hamming 8/4 check failed |
| no_frame | output | 1 | Window ended without a hit |

## Verification
The bench places junk bits just before the window start so that a design opening the window one bit early or late either misses or mis-aligns the pattern, and feeds a pattern with one too many flipped bits so that an off-by-one error comparison gives a byte instead of the expected `no_frame`. It sends a three-bit pattern at the very start of the window with full error tolerance, where a design that ignored the fill rule would hit on the first bit and deliver shifted bytes. It abandons a line mid-byte and strobes a bit in the same cycle as the next `line_start`; a design that counted that bit would complete the pattern and emit a byte. Hamming flags are checked with a bad codeword on a protected, an optional and an unprotected service, catching a flag raised or dropped for the wrong service.

// File: rtl/vbi_fc_pkg.sv
package vbi_fc_pkg;

    parameter int CODE_W = 24;
    parameter int LEN_W  = $clog2(CODE_W + 1);
    parameter int STD_W  = 4;

    typedef enum logic [STD_W-1:0] {
        SVC_TTX625 = 4'd0,
        SVC_CC     = 4'd1,
        SVC_PDL    = 4'd2,
        SVC_WSIG   = 4'd3,
        SVC_TTX525 = 4'd4,
        SVC_GTEXT  = 4'd5,
        SVC_TCODE  = 4'd6,
        SVC_NABTS  = 4'd7,
        SVC_JTEXT  = 4'd8
    } svc_e;

    typedef struct packed {
        logic              on;
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
        logic              ham;
    } svc_cfg_t;

    function automatic svc_cfg_t svc_lookup(input logic [STD_W-1:0] s,
                                            input logic [CODE_W-1:0] pcode,
                                            input logic [LEN_W-1:0]  plen,
                                            input logic              ham_opt);
        svc_cfg_t c;
        logic [LEN_W-1:0] cl;
        cl = (plen == '0) ? LEN_W'(1) : ((plen > LEN_W'(CODE_W)) ? LEN_W'(CODE_W) : plen);
        c  = '{on: 1'b1, code: '0, len: LEN_W'(1), ham: 1'b0};
        case (s)
            SVC_TTX625, SVC_TTX525: begin c.code = CODE_W'(24'h27);     c.len = LEN_W'(8);  c.ham = 1'b1; end
            SVC_CC:                 begin c.code = CODE_W'(24'h1);      c.len = LEN_W'(3);  end
            SVC_PDL:                begin c.code = CODE_W'(24'h9951);   c.len = LEN_W'(16); end
            SVC_WSIG:               begin c.code = CODE_W'(24'h1E3C1F); c.len = LEN_W'(24); end
            SVC_JTEXT:              begin c.code = CODE_W'(24'hA7);     c.len = LEN_W'(8);  end
            SVC_GTEXT, SVC_NABTS:   begin c.code = pcode; c.len = cl; c.ham = ham_opt; end
            SVC_TCODE:              begin c.code = pcode; c.len = cl; end
            default:                c.on = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic ham84_bad(input logic [7:0] b);
        return !(^{b[0], b[1], b[3], b[7]}) || !(^{b[1], b[2], b[3], b[5]}) ||
               !(^{b[3], b[4], b[5], b[7]}) || !(^b);
    endfunction

endpackage

// File: rtl/vbi_fc_match.sv
module vbi_fc_match #(
    parameter int CODE_W = 24,
    parameter int LEN_W  = $clog2(CODE_W + 1)
) (
    input  logic [CODE_W-1:0] window,
    input  logic [CODE_W-1:0] code,
    input  logic [LEN_W-1:0]  len,
    output logic [LEN_W-1:0]  mism
);
    logic [CODE_W-1:0] diff;

    always_comb begin
        mism = '0;
        for (int i = 0; i < CODE_W; i++) begin
            diff[i] = (window[i] ^ code[i]) & (LEN_W'(i) < len);
            mism    = mism + LEN_W'(diff[i]);
        end
    end
endmodule

// File: rtl/vbi_byte_pack.sv
module vbi_byte_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       shift,
    input  logic       bit_in,
    input  logic       ham_en,
    input  logic       first,
    output logic       vld,
    output logic [7:0] data,
    output logic       sop,
    output logic       herr
);
    import vbi_fc_pkg::*;

    logic [7:0] acc_q;
    logic [2:0] cnt_q;
    logic [7:0] full;

    assign full = {bit_in, acc_q[7:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            vld   <= 1'b0;
            data  <= '0;
            sop   <= 1'b0;
            herr  <= 1'b0;
        end else begin
            vld  <= 1'b0;
            sop  <= 1'b0;
            herr <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (shift) begin
                acc_q <= full;
                cnt_q <= cnt_q + 3'd1;
                if (cnt_q == 3'd7) begin
                    vld  <= 1'b1;
                    data <= full;
                    sop  <= first;
                    herr <= ham_en && ham84_bad(full);
                end
            end
        end
    end
endmodule

// File: rtl/vbi_frame_assembler.sv
module vbi_frame_assembler #(
    parameter int NUM_LINES = 8,
    parameter int VLINE_W   = 9,
    parameter int HOFF_W    = 11,
    parameter int WIN_BITS  = 256
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                line_start,
    input  logic [VLINE_W-1:0]                  line_num,
    input  logic                                bit_valid,
    input  logic                                bit_in,
    input  logic [NUM_LINES*vbi_fc_pkg::STD_W-1:0] line_std,
    input  logic [VLINE_W-1:0]                  v_off,
    input  logic [HOFF_W-1:0]                   h_off,
    input  logic [vbi_fc_pkg::LEN_W-1:0]        err_limit,
    input  logic [vbi_fc_pkg::CODE_W-1:0]       prog_code,
    input  logic [vbi_fc_pkg::LEN_W-1:0]        prog_len,
    input  logic                                ham_opt_en,
    output logic                                byte_valid,
    output logic [7:0]                          byte_data,
    output logic                                byte_sop,
    output logic                                byte_ham_err,
    output logic                                no_frame
);
    import vbi_fc_pkg::*;

    localparam int POS_W = HOFF_W + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_COLLECT} st_e;

    st_e               st_q, st_d;
    logic [POS_W-1:0]  pos_q, hoff_q, wend_q;
    logic [CODE_W-1:0] sr_q, sr_nxt;
    logic [LEN_W-1:0]  fill_q, fill_nxt, lim_q, mism;
    svc_cfg_t          cfg_q, line_cfg;
    logic              first_q;
    logic [VLINE_W-1:0] idx;
    logic [STD_W-1:0]  sel;
    logic              line_on, in_win, last, take, hit;

    // line selection
    always_comb begin
        idx = line_num - v_off;
        sel = '1;
        for (int i = 0; i < NUM_LINES; i++)
            if (idx == VLINE_W'(i)) sel = line_std[i*STD_W +: STD_W];
        line_cfg = svc_lookup(sel, prog_code, prog_len, ham_opt_en);
        line_on  = line_cfg.on && (idx < VLINE_W'(NUM_LINES));
    end

    assign in_win   = (pos_q >= hoff_q) && (pos_q <= wend_q);
    assign last     = (pos_q == wend_q);
    assign take     = bit_valid && !line_start && (st_q != ST_IDLE) && in_win;
    assign sr_nxt   = {sr_q[CODE_W-2:0], bit_in};
    assign fill_nxt = (fill_q == LEN_W'(CODE_W)) ? fill_q : fill_q + LEN_W'(1);
    assign hit      = (fill_nxt >= cfg_q.len) && (mism <= lim_q);

    vbi_fc_match #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_match (
        .window (sr_nxt),
        .code   (cfg_q.code),
        .len    (cfg_q.len),
        .mism   (mism)
    );

    vbi_byte_pack u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (st_q == ST_HUNT && take && hit),
        .shift  (st_q == ST_COLLECT && take),
        .bit_in (bit_in),
        .ham_en (cfg_q.ham),
        .first  (first_q),
        .vld    (byte_valid),
        .data   (byte_data),
        .sop    (byte_sop),
        .herr   (byte_ham_err)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (line_start && line_on) st_d = ST_HUNT;
            ST_HUNT: begin
                if (line_start)       st_d = line_on ? ST_HUNT : ST_IDLE;
                else if (take && last) st_d = ST_IDLE;
                else if (take && hit)  st_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (line_start)       st_d = line_on ? ST_HUNT : ST_IDLE;
                else if (take && last) st_d = ST_IDLE;
            end
            default:                   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // line datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            hoff_q  <= '0;
            wend_q  <= '0;
            sr_q    <= '0;
            fill_q  <= '0;
            lim_q   <= '0;
            cfg_q   <= '0;
            first_q <= 1'b0;
        end else if (line_start) begin
            pos_q   <= '0;
            hoff_q  <= POS_W'(h_off);
            wend_q  <= POS_W'(h_off) + POS_W'(WIN_BITS - 1);
            sr_q    <= '0;
            fill_q  <= '0;
            lim_q   <= err_limit;
            cfg_q   <= line_cfg;
            first_q <= 1'b1;
        end else begin
            if (bit_valid && st_q != ST_IDLE) pos_q <= pos_q + POS_W'(1);
            if (take && st_q == ST_HUNT) begin
                sr_q   <= sr_nxt;
                fill_q <= fill_nxt;
            end
            if (byte_valid) first_q <= 1'b0;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) no_frame <= 1'b0;
        else        no_frame <= (st_q == ST_HUNT) && take && last && !hit;
    end
endmodule

// File: rtl/vbi_fa_checker.sv
module vbi_fa_checker (
    input logic clk,
    input logic rst_n,
    input logic line_start,
    input logic byte_valid,
    input logic byte_sop,
    input logic byte_ham_err,
    input logic no_frame
);
    always @(posedge clk) begin
        if (rst_n === 1'b0)
            assert_reset_quiet_R1: assert (!byte_valid && !byte_sop && !byte_ham_err && !no_frame);
    end

    assert_nf_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        no_frame |=> !no_frame);

    assert_nf_no_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(no_frame && byte_valid));

    assert_byte_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    assert_sop_with_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_sop |-> byte_valid);

    assert_herr_with_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ham_err |-> byte_valid);

    assert_restart_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (!byte_valid && !no_frame));
endmodule

bind vbi_frame_assembler vbi_fa_checker u_fa_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start   (line_start),
    .byte_valid   (byte_valid),
    .byte_sop     (byte_sop),
    .byte_ham_err (byte_ham_err),
    .no_frame     (no_frame)
);

// File: tb/tb_vbi_frame_assembler.sv
`timescale 1ns/1ps
module tb_vbi_frame_assembler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [8:0]  line_num = '0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [31:0] line_std = '1;
    logic [8:0]  v_off = '0;
    logic [10:0] h_off = '0;
    logic [4:0]  err_limit = '0;
    logic [23:0] prog_code = '0;
    logic [4:0]  prog_len = 5'd8;
    logic        ham_opt_en = 1'b0;
    logic        byte_valid, byte_sop, byte_ham_err, no_frame;
    logic [7:0]  byte_data;

    int n_chk = 0, n_bad = 0, nf_cnt = 0;
    logic [7:0] rx_d[$];
    bit rx_s[$];
    bit rx_e[$];
    logic [7:0] good_b, bad_b;

    always #2.5 clk = ~clk;

    vbi_frame_assembler dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
        .bit_valid(bit_valid), .bit_in(bit_in), .line_std(line_std), .v_off(v_off),
        .h_off(h_off), .err_limit(err_limit), .prog_code(prog_code), .prog_len(prog_len),
        .ham_opt_en(ham_opt_en), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_sop(byte_sop), .byte_ham_err(byte_ham_err), .no_frame(no_frame)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                rx_d.push_back(byte_data);
                rx_s.push_back(byte_sop);
                rx_e.push_back(byte_ham_err);
            end
            if (no_frame) nf_cnt++;
        end
    end

    function automatic bit ham_bad(input logic [7:0] b);
        return !(^{b[0], b[1], b[3], b[7]}) || !(^{b[1], b[2], b[3], b[5]}) ||
               !(^{b[3], b[4], b[5], b[7]}) || !(^b);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_rx();
        rx_d.delete(); rx_s.delete(); rx_e.delete(); nf_cnt = 0;
    endtask

    task automatic begin_line(input logic [8:0] num);
        @(negedge clk); line_start = 1'b1; line_num = num; bit_valid = 1'b0;
        @(negedge clk); line_start = 1'b0;
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); bit_valid = 1'b0; end
    endtask

    task automatic send_code(input logic [23:0] c, input int len);
        for (int i = len - 1; i >= 0; i--) drive_bit(c[i]);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
    endtask

    task automatic send_fill(input int n);
        for (int i = 0; i < n; i++) drive_bit(1'b0);
    endtask

    task automatic t_reset();
        chk("R1", "byte_valid in reset", int'(byte_valid), 0);
        chk("R1", "no_frame in reset", int'(no_frame), 0);
        @(negedge clk); rst_n = 1'b1;
        send_code(24'h27, 8); send_byte(good_b); idle(3);
        chk("R1", "bytes with no line started", rx_d.size(), 0);
    endtask

    task automatic t_teletext();
        clear_rx();
        line_std = '1; line_std[3:0] = 4'd0; v_off = 9'd10; h_off = 11'd3; err_limit = 5'd0;
        begin_line(9'd10);
        drive_bit(1); drive_bit(1); drive_bit(1);
        send_code(24'h27, 8); send_byte(good_b); send_byte(bad_b);
        drive_bit(1); drive_bit(0); drive_bit(1); idle(3);
        chk("R8", "teletext byte count", rx_d.size(), 2);
        if (rx_d.size() == 2) begin
            chk("R8", "first byte", rx_d[0], good_b);
            chk("R9", "sop on first byte", rx_s[0], 1);
            chk("R10", "good codeword flag", rx_e[0], 0);
            chk("R8", "second byte", rx_d[1], bad_b);
            chk("R9", "sop on second byte", rx_s[1], 0);
            chk("R10", "bad codeword flag", rx_e[1], 1);
        end
        chk("R7", "no_frame on hit line", nf_cnt, 0);
    endtask

    task automatic t_errors();
        clear_rx();
        line_std = '1; line_std[7:4] = 4'd2; v_off = 9'd0; h_off = 11'd0; err_limit = 5'd2;
        begin_line(9'd1);
        send_code(24'h9951 ^ 24'h0011, 16); send_byte(8'h5A); idle(3);
        chk("R5", "two errors at limit two", rx_d.size(), 1);
        if (rx_d.size() == 1) begin
            chk("R3", "PDL byte", rx_d[0], 8'h5A);
            chk("R10", "PDL never flags", rx_e[0], 0);
        end
        clear_rx();
        err_limit = 5'd0;
        begin_line(9'd1);
        send_code(24'h9951 ^ 24'h0100, 16); send_fill(240); idle(3);
        chk("R5", "one error at limit zero", rx_d.size(), 0);
        chk("R7", "no_frame count", nf_cnt, 1);
    endtask

    task automatic t_short_code();
        clear_rx();
        line_std = '1; line_std[3:0] = 4'd1; v_off = 9'd0; h_off = 11'd0; err_limit = 5'd3;
        begin_line(9'd0);
        drive_bit(1); drive_bit(1); drive_bit(0);
        send_byte(bad_b); idle(3);
        chk("R4", "fill rule byte count", rx_d.size(), 1);
        if (rx_d.size() == 1) begin
            chk("R4", "fill rule alignment", rx_d[0], bad_b);
            chk("R10", "caption never flags", rx_e[0], 0);
        end
    endtask

    task automatic t_programmable();
        clear_rx();
        line_std = '1; line_std[3:0] = 4'd5; h_off = 11'd0; err_limit = 5'd0;
        prog_code = 24'hA5C; prog_len = 5'd12; ham_opt_en = 1'b1;
        begin_line(9'd0);
        send_code(24'hA5C, 12); send_byte(bad_b); idle(3);
        chk("R10", "optional check on", (rx_e.size() == 1) ? int'(rx_e[0]) : -1, 1);
        clear_rx();
        ham_opt_en = 1'b0;
        begin_line(9'd0);
        send_code(24'hA5C, 12); send_byte(bad_b); idle(3);
        chk("R10", "optional check off", (rx_e.size() == 1) ? int'(rx_e[0]) : -1, 0);
        chk("R3", "programmable byte", (rx_d.size() == 1) ? int'(rx_d[0]) : -1, bad_b);
    endtask

    task automatic t_long_code();
        clear_rx();
        line_std = '1; line_std[3:0] = 4'd3; h_off = 11'd0; err_limit = 5'd0;
        begin_line(9'd0);
        send_code(24'h1E3C1F, 24); send_byte(8'hC3); idle(3);
        chk("R3", "widescreen byte", (rx_d.size() == 1) ? int'(rx_d[0]) : -1, 8'hC3);
        clear_rx();
        line_std[3:0] = 4'd8;
        begin_line(9'd0);
        send_code(24'hA7, 8); send_byte(8'h81); idle(3);
        chk("R3", "japanese text byte", (rx_d.size() == 1) ? int'(rx_d[0]) : -1, 8'h81);
    endtask

    task automatic t_select();
        clear_rx();
        line_std = '1; line_std[11:8] = 4'd0; v_off = 9'd20; h_off = 11'd0; err_limit = 5'd0;
        begin_line(9'd22);
        send_code(24'h27, 8); send_byte(good_b); idle(3);
        chk("R2", "selected line bytes", rx_d.size(), 1);
        clear_rx();
        begin_line(9'd30);
        send_code(24'h27, 8); send_byte(good_b); idle(3);
        begin_line(9'd19);
        send_code(24'h27, 8); send_byte(good_b); idle(3);
        begin_line(9'd21);
        send_code(24'h27, 8); send_byte(good_b); idle(3);
        chk("R2", "unselected line bytes", rx_d.size(), 0);
        chk("R2", "unselected line no_frame", nf_cnt, 0);
    endtask

    task automatic t_window();
        clear_rx();
        line_std = '1; line_std[3:0] = 4'd0; v_off = 9'd0; h_off = 11'd16; err_limit = 5'd0;
        begin_line(9'd0);
        send_code(24'h27, 8); send_fill(264); idle(3);
        chk("R6", "pattern before window", rx_d.size(), 0);
        chk("R7", "no_frame after window", nf_cnt, 1);
    endtask

    task automatic t_restart();
        clear_rx();
        line_std = '1; line_std[3:0] = 4'd0; v_off = 9'd0; h_off = 11'd0; err_limit = 5'd0;
        begin_line(9'd0);
        send_code(24'h27, 8); drive_bit(1); drive_bit(0); drive_bit(1); drive_bit(1);
        @(negedge clk); line_start = 1'b1; line_num = 9'd0; bit_valid = 1'b1; bit_in = 1'b0;
        @(negedge clk); line_start = 1'b0; bit_valid = 1'b1; bit_in = 1'b0;
        drive_bit(1); drive_bit(0); drive_bit(0); drive_bit(1); drive_bit(1); drive_bit(1);
        send_byte(8'hFF); idle(3);
        chk("R11", "bytes after restart with dropped bit", rx_d.size(), 0);
        begin_line(9'd0);
        send_code(24'h27, 8); send_byte(8'h3C); idle(3);
        chk("R11", "bytes on clean line", rx_d.size(), 1);
        if (rx_d.size() == 1) chk("R9", "sop on new line", rx_s[0], 1);
    endtask

    initial begin
        for (int b = 0; b < 256; b++)
            if (!ham_bad(8'(b))) begin good_b = 8'(b); break; end
        bad_b = good_b ^ 8'h01;
        repeat (3) @(negedge clk);
        t_reset();
        t_teletext();
        t_errors();
        t_short_code();
        t_programmable();
        t_long_code();
        t_select();
        t_window();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule